// File: doc/BRIEF.md
# Cascadable Eight-Input Priority Interrupt Controller

The block collects eight interrupt lines, keeps a request register, an in-service register and a mask register, and picks the most urgent unmasked request under fixed priority (line 0 most urgent). It raises `int_req` when a request may be presented and returns an 8-bit vector one cycle after an acknowledge pulse. Software programs it through a byte-wide port with two addresses: address 0 takes command bytes and reads status, address 1 takes initialization and mask bytes and reads the mask.

Configuration is a small state machine. `ST_IDLE` is the state after reset. A command byte 0x11 moves any state to `ST_GET_BASE`. Each address-1 write then steps `ST_GET_BASE` to `ST_GET_CASC` (vector base taken), `ST_GET_CASC` to `ST_GET_MODE` (cascade word taken), and `ST_GET_MODE` to `ST_RUN` (mode word taken). `ST_RUN` holds until the next 0x11. Only in `ST_RUN` are mask writes, end-of-interrupt and read-select commands accepted and requests presented.

Each line may be edge or level triggered through a trigger register; lines chosen by a parameter are always edge triggered. In master mode, an acknowledged line that has a slave behind it makes the block drive the line number on the cascade bus instead of a vector; in slave mode it answers an acknowledge only when the cascade bus carries its own identity.

Top module: `pic8_ctrl`

## Requirements
- R1: After reset the block is in `ST_IDLE`, `int_req` is 0, address-0 reads return 0 (request register), address-1 reads return 0xFF (mask) and `trig_mode` is 0.
- R2: Command 0x11 clears the in-service register and edge requests and starts initialization; the next three address-1 writes are vector base, cascade word and mode word, they do not change the mask, and `int_req` stays 0 until the mode word is taken.
- R3: One cycle after an accepted `int_ack` pulse, `vec_valid` is 1 for one cycle with `vec_data` = {base bits 7:3, line number}.
- R4: Line 0 is most urgent; a request is presented only when no in-service bit at its own or a more urgent level is set.
- R5: In `ST_RUN` an address-1 write loads the mask; a 1 bit masks that line, and a masked request never raises `int_req`.
- R6: Command 0x60+L (L = 0..7) in `ST_RUN` clears in-service bit L only.
- R7: With mode-word bit 1 set (automatic end-of-interrupt), an acknowledge sets no in-service bit.
- R8: Command 0x0B selects the in-service register and 0x0A the request register for address-0 reads; the choice persists across other writes.
- R9: An acknowledge with no presentable request returns {base, 7} and sets no in-service bit, even if line 7 is masked.
- R10: An edge line's request is set on a rising edge, cleared when it goes in service or when the line falls; a level line's request follows the line one cycle later.
- R11: `trig_we` loads the trigger register (1 = level, 0 = edge); bits set in `EDGE_ONLY` read 0 and stay edge.
- R12: In master mode an acknowledged line whose cascade-word bit is 1 gives a one-cycle `cas_drive` with `cas_out` = line and no `vec_valid`; in slave mode an acknowledge is ignored unless `cas_in` equals cascade-word bits 2:0.
- R13: An end-of-interrupt and an acknowledge in the same cycle both take effect; the acknowledged level's in-service bit ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 = command/status, 1 = data/mask |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Read byte (combinational) |
| irq_lines | input | 8 | Interrupt inputs |
| trig_we | input | 1 | Trigger register write strobe |
| trig_wdata | input | 8 | Trigger register value |
| trig_mode | output | 8 | Trigger register contents |
| is_master | input | 1 | 1 = master, 0 = slave |
| cas_in | input | 3 | Cascade identity seen by a slave |
| int_req | output | 1 | Interrupt request to the processor |
| int_ack | input | 1 | Acknowledge pulse |
| vec_valid | output | 1 | Vector returned this cycle |
| vec_data | output | 8 | Vector |
| cas_drive | output | 1 | Master hands the acknowledge to a slave |
| cas_out | output | 3 | Line number driven on the cascade bus |

## Verification
The sharpest overlap is an end-of-interrupt write landing in the same cycle as an acknowledge: the clear and the set act on the in-service register together. The bench drives the 0x60+L write and the `int_ack` pulse in one cycle, once for the acknowledged level itself and once for a different level already in service, and then reads the in-service register to see that the new level is set and the old one cleared. A request vanishing just before its acknowledge is provoked separately and judged by the spurious vector and an unchanged in-service register.

// File: rtl/pic8_pkg.sv
package pic8_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GET_BASE,
        ST_GET_CASC,
        ST_GET_MODE,
        ST_RUN
    } cfg_state_t;

    localparam logic [7:0] CMD_INIT    = 8'h11;
    localparam logic [7:0] CMD_SEL_IRR = 8'h0A;
    localparam logic [7:0] CMD_SEL_ISR = 8'h0B;
    localparam logic [4:0] CMD_EOI_TOP = 5'b01100;
    localparam int         MODE_AUTO_BIT = 1;

endpackage

// File: rtl/pic8_cfg.sv
module pic8_cfg
    import pic8_pkg::*;
#(
    parameter int LVL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic             ready,
    output logic [7-LVL_W:0] vec_hi,
    output logic [7:0]       casc_word,
    output logic             auto_eoi,
    output logic [7:0]       mask_q,
    output logic             sel_isr,
    output logic             init_pulse,
    output logic             eoi_vld,
    output logic [LVL_W-1:0] eoi_lvl
);

    cfg_state_t state_q, state_n;
    logic cmd_wr, dat_wr;

    assign cmd_wr     = bus_wr & ~bus_addr;
    assign dat_wr     = bus_wr &  bus_addr;
    assign ready      = (state_q == ST_RUN);
    assign init_pulse = cmd_wr && (bus_wdata == CMD_INIT);
    assign eoi_vld    = ready && cmd_wr && (bus_wdata[7:LVL_W] == CMD_EOI_TOP);
    assign eoi_lvl    = bus_wdata[LVL_W-1:0];

    always_comb begin
        state_n = state_q;
        if (init_pulse) begin
            state_n = ST_GET_BASE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_n = ST_IDLE;
                ST_GET_BASE: if (dat_wr) state_n = ST_GET_CASC;
                ST_GET_CASC: if (dat_wr) state_n = ST_GET_MODE;
                ST_GET_MODE: if (dat_wr) state_n = ST_RUN;
                ST_RUN:      state_n = ST_RUN;
                default:     state_n = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_hi    <= '0;
            casc_word <= '0;
            auto_eoi  <= 1'b0;
            mask_q    <= 8'hFF;
            sel_isr   <= 1'b0;
        end else if (init_pulse) begin
            sel_isr <= 1'b0;
        end else begin
            unique case (state_q)
                ST_GET_BASE: if (dat_wr) vec_hi <= bus_wdata[7:LVL_W];
                ST_GET_CASC: if (dat_wr) casc_word <= bus_wdata;
                ST_GET_MODE: if (dat_wr) auto_eoi <= bus_wdata[MODE_AUTO_BIT];
                ST_RUN: begin
                    if (dat_wr) mask_q <= bus_wdata;
                    if (cmd_wr && bus_wdata == CMD_SEL_IRR) sel_isr <= 1'b0;
                    if (cmd_wr && bus_wdata == CMD_SEL_ISR) sel_isr <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/pic8_req.sv
module pic8_req #(
    parameter int         N_IN      = 8,
    parameter logic [7:0] EDGE_ONLY = 8'h07
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_IN-1:0] lines,
    input  logic            trig_we,
    input  logic [N_IN-1:0] trig_wdata,
    input  logic [N_IN-1:0] ack_clr,
    input  logic            clr_all,
    output logic [N_IN-1:0] trig_q,
    output logic [N_IN-1:0] irr_q
);

    logic [N_IN-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) trig_q <= '0;
        else if (trig_we) trig_q <= trig_wdata & ~EDGE_ONLY[N_IN-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            irr_q  <= '0;
        end else begin
            prev_q <= lines;
            for (int i = 0; i < N_IN; i++) begin
                if (trig_q[i])             irr_q[i] <= lines[i];
                else if (!lines[i])        irr_q[i] <= 1'b0;
                else if (!prev_q[i])       irr_q[i] <= 1'b1;
                else if (ack_clr[i] || clr_all) irr_q[i] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/pic8_prio.sv
module pic8_prio #(
    parameter int N_IN  = 8,
    parameter int LVL_W = 3
) (
    input  logic [N_IN-1:0]  irr,
    input  logic [N_IN-1:0]  mask,
    input  logic [N_IN-1:0]  isr,
    output logic             present,
    output logic [LVL_W-1:0] lvl
);

    logic [N_IN-1:0] pend;
    logic            done;

    assign pend = irr & ~mask;

    always_comb begin
        present = 1'b0;
        lvl     = '0;
        done    = 1'b0;
        for (int i = 0; i < N_IN; i++) begin
            if (!done && isr[i]) begin
                done = 1'b1;
            end else if (!done && pend[i]) begin
                done    = 1'b1;
                present = 1'b1;
                lvl     = LVL_W'(i);
            end
        end
    end

endmodule

// File: rtl/pic8_ctrl.sv
module pic8_ctrl
    import pic8_pkg::*;
#(
    parameter int         N_IN      = 8,
    parameter logic [7:0] EDGE_ONLY = 8'h07
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic       bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic [7:0] irq_lines,
    input  logic       trig_we,
    input  logic [7:0] trig_wdata,
    output logic [7:0] trig_mode,
    input  logic       is_master,
    input  logic [2:0] cas_in,
    output logic       int_req,
    input  logic       int_ack,
    output logic       vec_valid,
    output logic [7:0] vec_data,
    output logic       cas_drive,
    output logic [2:0] cas_out
);

    localparam int LVL_W = $clog2(N_IN);
    localparam logic [LVL_W-1:0] LOWEST = LVL_W'(N_IN - 1);

    logic             cfg_ready, auto_eoi, sel_isr, init_pulse, eoi_vld;
    logic [7-LVL_W:0] vec_hi;
    logic [7:0]       casc_word, mask_q;
    logic [LVL_W-1:0] eoi_lvl, win_lvl;
    logic [7:0]       irr_q, isr_q, isr_n, ack_clr;
    logic             win_ok, ack_ok, to_slave;

    pic8_cfg #(.LVL_W(LVL_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .ready(cfg_ready), .vec_hi(vec_hi),
        .casc_word(casc_word), .auto_eoi(auto_eoi), .mask_q(mask_q),
        .sel_isr(sel_isr), .init_pulse(init_pulse), .eoi_vld(eoi_vld),
        .eoi_lvl(eoi_lvl)
    );

    pic8_req #(.N_IN(N_IN), .EDGE_ONLY(EDGE_ONLY)) u_req (
        .clk(clk), .rst_n(rst_n), .lines(irq_lines), .trig_we(trig_we),
        .trig_wdata(trig_wdata), .ack_clr(ack_clr), .clr_all(init_pulse),
        .trig_q(trig_mode), .irr_q(irr_q)
    );

    pic8_prio #(.N_IN(N_IN), .LVL_W(LVL_W)) u_prio (
        .irr(irr_q), .mask(mask_q), .isr(isr_q),
        .present(win_ok), .lvl(win_lvl)
    );

    assign ack_ok   = int_ack && cfg_ready &&
                      (is_master || cas_in == casc_word[LVL_W-1:0]);
    assign to_slave = is_master && win_ok && casc_word[win_lvl];
    assign ack_clr  = (ack_ok && win_ok) ? (8'h01 << win_lvl) : 8'h00;
    assign int_req  = cfg_ready && win_ok;
    assign bus_rdata = bus_addr ? mask_q : (sel_isr ? isr_q : irr_q);

    always_comb begin
        isr_n = isr_q;
        if (init_pulse) begin
            isr_n = '0;
        end else begin
            if (eoi_vld) isr_n[eoi_lvl] = 1'b0;
            if (ack_ok && win_ok && !auto_eoi) isr_n[win_lvl] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) isr_q <= '0;
        else        isr_q <= isr_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            vec_data  <= '0;
            cas_drive <= 1'b0;
            cas_out   <= '0;
        end else begin
            vec_valid <= ack_ok && !to_slave;
            cas_drive <= ack_ok && to_slave;
            if (ack_ok) begin
                vec_data <= {vec_hi, (win_ok ? win_lvl : LOWEST)};
                cas_out  <= to_slave ? win_lvl : '0;
            end
        end
    end

endmodule

// File: rtl/pic8_ctrl_chk.sv
module pic8_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ready,
    input logic       auto_eoi,
    input logic       present,
    input logic       int_req,
    input logic       int_ack,
    input logic       vec_valid,
    input logic       cas_drive,
    input logic [7:0] isr,
    input logic [7:0] irr,
    input logic [7:0] mask
);

    AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        !ready |-> !int_req); // R2

    AST_VEC_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(int_ack)); // R3

    AST_REQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> ((irr & ~mask) != 8'h00)); // R5

    AST_AUTO_ISR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && auto_eoi) |-> (isr == 8'h00)); // R7

    AST_SPUR_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (int_ack && ready && !present) |=> ((isr & ~$past(isr)) == 8'h00)); // R9

    AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        !(vec_valid && cas_drive)); // R12

endmodule

bind pic8_ctrl pic8_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ready(cfg_ready), .auto_eoi(auto_eoi),
    .present(win_ok), .int_req(int_req), .int_ack(int_ack),
    .vec_valid(vec_valid), .cas_drive(cas_drive), .isr(isr_q),
    .irr(irr_q), .mask(mask_q)
);

// File: tb/pic8_ctrl_tb.sv
module pic8_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0, bus_addr = 1'b0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [7:0] irq_lines = '0;
    logic       trig_we = 1'b0;
    logic [7:0] trig_wdata = '0, trig_mode;
    logic       is_master = 1'b1;
    logic [2:0] cas_in = '0;
    logic       int_req, int_ack = 1'b0;
    logic       vec_valid, cas_drive;
    logic [7:0] vec_data;
    logic [2:0] cas_out;
    int checks = 0, fails = 0;
    logic [7:0] rv;

    always #4 clk = ~clk;

    pic8_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_lines(irq_lines),
        .trig_we(trig_we), .trig_wdata(trig_wdata), .trig_mode(trig_mode),
        .is_master(is_master), .cas_in(cas_in), .int_req(int_req),
        .int_ack(int_ack), .vec_valid(vec_valid), .vec_data(vec_data),
        .cas_drive(cas_drive), .cas_out(cas_out)
    );

    // {mask, lines}; line 2 is kept out because it carries a slave
    localparam logic [15:0] TBL [6] = '{16'h0001, 16'h0088, 16'h0888,
                                        16'hF030, 16'h00C0, 16'h7F80};

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr(logic a, logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(logic a, output logic [7:0] d);
        @(negedge clk); bus_addr = a; #1 d = bus_rdata;
    endtask

    task automatic ack(logic [2:0] c);
        @(negedge clk); int_ack = 1'b1; cas_in = c;
        @(negedge clk); int_ack = 1'b0;
    endtask

    task automatic lines(logic [7:0] v);
        @(negedge clk); irq_lines = v;
        @(negedge clk);
    endtask

    task automatic isr_is(string req, logic [7:0] exp);
        wr(0, 8'h0B); rd(0, rv); chk(req, rv, exp); wr(0, 8'h0A);
    endtask

    task automatic eoi_ack(logic [2:0] l);
        @(negedge clk); bus_wr = 1'b1; bus_addr = 1'b0; bus_wdata = 8'h60 + 8'(l); int_ack = 1'b1;
        @(negedge clk); bus_wr = 1'b0; int_ack = 1'b0;
    endtask

    function automatic logic [3:0] pick(logic [7:0] m, logic [7:0] l);
        for (int i = 0; i < 8; i++)
            if (l[i] && !m[i]) return {1'b1, 3'(i)};
        return 4'h7;
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%02h expected=%02h", 8'h00, 8'h01);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd(0, rv); chk("R1 irr", rv, 8'h00);
        rd(1, rv); chk("R1 mask", rv, 8'hFF);
        chk("R1 int_req", {7'd0, int_req}, 8'h00);
        chk("R1 trig", trig_mode, 8'h00);
        // R2 initialization: base 0x20, slave on line 2, normal EOI
        wr(0, 8'h11); wr(1, 8'h20); wr(1, 8'h04); wr(1, 8'h01);
        rd(1, rv); chk("R2 mask untouched", rv, 8'hFF);
        // table walk: R3 R5 R6 R9
        for (int k = 0; k < 6; k++) begin
            logic [7:0] m, l;
            logic [3:0] e;
            m = TBL[k][15:8]; l = TBL[k][7:0]; e = pick(m, l);
            wr(1, m);
            lines(l);
            chk("R5 int_req", {7'd0, int_req}, {7'd0, e[3]});
            ack(3'd0);
            chk("R3 vec_valid", {7'd0, vec_valid}, 8'h01);
            chk("R3 vec", vec_data, 8'h20 | {5'd0, e[2:0]});
            isr_is("R9 R4 isr after ack", e[3] ? (8'h01 << e[2:0]) : 8'h00);
            wr(0, 8'h60 + {5'd0, e[2:0]});
            isr_is("R6 isr after eoi", 8'h00);
            lines(8'h00);
        end
        wr(1, 8'h00);
        // R4 nesting and R6 single-level clear
        lines(8'h20); ack(3'd0); chk("R4 vec5", vec_data, 8'h25);
        lines(8'h60); chk("R4 blocked", {7'd0, int_req}, 8'h00);
        lines(8'h62); chk("R4 higher passes", {7'd0, int_req}, 8'h01);
        ack(3'd0); chk("R4 vec1", vec_data, 8'h21);
        isr_is("R4 nested isr", 8'h22);
        wr(0, 8'h61); isr_is("R6 only level1", 8'h20);
        chk("R4 six still blocked", {7'd0, int_req}, 8'h00);
        wr(0, 8'h65); chk("R4 six free", {7'd0, int_req}, 8'h01);
        ack(3'd0); chk("R4 vec6", vec_data, 8'h26);
        wr(0, 8'h66); lines(8'h00);
        // R8 persistence
        lines(8'h08); ack(3'd0);
        wr(0, 8'h0B); wr(1, 8'h00); wr(0, 8'h15);
        rd(0, rv); chk("R8 isr kept", rv, 8'h08);
        wr(0, 8'h0A); rd(0, rv); chk("R8 irr back", rv, 8'h00);
        wr(0, 8'h63); lines(8'h00);
        // R11 trigger register, R10 level
        @(negedge clk); trig_we = 1'b1; trig_wdata = 8'hFF;
        @(negedge clk); trig_we = 1'b0;
        chk("R11 forced edge", trig_mode, 8'hF8);
        lines(8'h80); ack(3'd0); chk("R10 level vec", vec_data, 8'h27);
        wr(0, 8'h67); chk("R10 level stays", {7'd0, int_req}, 8'h01);
        rd(0, rv); chk("R10 level irr", rv, 8'h80);
        lines(8'h00); rd(0, rv); chk("R10 level drop", rv, 8'h00);
        @(negedge clk); trig_we = 1'b1; trig_wdata = 8'h00;
        @(negedge clk); trig_we = 1'b0;
        // R10 edge held high does not re-request
        lines(8'h10); ack(3'd0); chk("R10 edge vec", vec_data, 8'h24);
        wr(0, 8'h64); lines(8'h10);
        chk("R10 edge no rerequest", {7'd0, int_req}, 8'h00);
        lines(8'h00);
        // R9 vanished request
        lines(8'h08); lines(8'h00);
        chk("R10 fall clears", {7'd0, int_req}, 8'h00);
        ack(3'd0); chk("R9 spurious vec", vec_data, 8'h27);
        isr_is("R9 isr clean", 8'h00);
        // R13 same-cycle EOI and acknowledge
        lines(8'h08); eoi_ack(3'd3);
        chk("R13 vec", vec_data, 8'h23);
        isr_is("R13 same level", 8'h08);
        wr(0, 8'h63); lines(8'h00);
        lines(8'h20); ack(3'd0);
        lines(8'h28); eoi_ack(3'd5);
        chk("R13 vec other", vec_data, 8'h23);
        isr_is("R13 other level", 8'h08);
        wr(0, 8'h63); lines(8'h00);
        // R12 master hands off to slave on line 2
        lines(8'h04); ack(3'd0);
        chk("R12 no vec", {7'd0, vec_valid}, 8'h00);
        chk("R12 cas_drive", {7'd0, cas_drive}, 8'h01);
        chk("R12 cas_out", {5'd0, cas_out}, 8'h02);
        wr(0, 8'h62); lines(8'h00);
        // R2 R7 reinit with automatic EOI, base 0x28
        wr(0, 8'h11); wr(1, 8'h28); wr(1, 8'h04);
        lines(8'h01);
        chk("R2 no req during init", {7'd0, int_req}, 8'h00);
        wr(1, 8'h03);
        chk("R2 req after mode", {7'd0, int_req}, 8'h01);
        ack(3'd0); chk("R3 new base", vec_data, 8'h28);
        isr_is("R7 auto eoi", 8'h00);
        lines(8'h00);
        // R12 slave identity match
        is_master = 1'b0;
        wr(0, 8'h11); wr(1, 8'h28); wr(1, 8'h02); wr(1, 8'h01);
        lines(8'h01);
        ack(3'd1);
        chk("R12 slave ignores", {6'd0, vec_valid, cas_drive}, 8'h00);
        chk("R12 slave req kept", {7'd0, int_req}, 8'h01);
        ack(3'd2);
        chk("R12 slave answers", {7'd0, vec_valid}, 8'h01);
        chk("R12 slave vec", vec_data, 8'h28);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule